// File: doc/BRIEF.md
# Write-Through Data Cache with Inhibit Bypass

This block is a small direct-mapped data cache placed between a processor load/store port and a simple request/acknowledge memory bus. It holds 16 lines of 16 bytes each. A cacheable read that misses fetches the whole aligned line as four 32-bit bus reads, starting from the lowest word. Writes go to the bus every time. A write that hits also updates the stored copy. A write never allocates a line.

Memory-mapped devices need accesses that are never cached and never widened. For this, every access carries an inhibit flag, driven by an address decoder or a translation unit, and a lock flag that marks read-modify-write cycles. Either flag, or a cleared enable bit, turns the access into exactly one bus transfer at the processor's own address and byte lanes. Such an access does no line fill and no allocation. A separate control port sets three things: an enable bit, a freeze bit that stops new allocation while hits are still served, and a self-clearing bit that invalidates every line in one cycle. The block has no snoop or external invalidate input, so software keeps the cache coherent with other bus masters.

The processor raises `cpu_req` and holds its request fields steady until `cpu_ready` pulses for one cycle. A read returns its data on `cpu_rdata` in that same cycle.

Top module: `dcache_bypass`

## Requirements
- R1: After reset all lines are invalid and the enable and freeze bits are 0, while `bus_req` and `cpu_ready` are low. With enable at 0 the first read is therefore a single bus transfer.
- R2: A read that is cacheable and misses issues four bus reads with `bus_be`=4'hF, `bus_lock`=0, at the line base plus 0, 4, 8, 12 in that order. It then returns the requested word and leaves the line valid. A read is cacheable when enable=1, inhibit=0, lock=0 and freeze=0. The line base is the address with bits 3:0 cleared, the index is bits 7:4 and the tag is bits 31:8.
- R3: A cacheable read that hits makes no bus request and raises `cpu_ready` in the cycle after the request is first seen.
- R4: An inhibited read issues exactly one bus read at `cpu_addr` with `cpu_be` and returns the bus data, even when the address hits. It neither allocates a line nor changes a cached word.
- R5: A locked access (read or write) is always one bus transfer with `bus_lock`=1 at `cpu_addr`, regardless of inhibit, enable or hit state, and it never allocates.
- R6: Every write is one bus write carrying `cpu_addr`, `cpu_wdata` and `cpu_be`. When the address hits a valid line, the enabled bytes of the cached word are updated, whether or not the write is bypassed. A write miss allocates nothing.
- R7: With freeze=1, hits are still served from the cache. A read miss becomes one bus transfer and no line is ever made valid.
- R8: With enable=0, every access behaves as inhibited.
- R9: The control register is written through `cfg_we`/`cfg_wdata`, with bit 0 enable, bit 1 freeze and bit 2 clear-all. Clear-all invalidates every line in the cycle it is written, and it is not stored.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_addr`, `bus_we` and `bus_be` stay unchanged.
- R11: `cpu_ready` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | bit0 enable, bit1 freeze, bit2 clear-all |
| cpu_req | input | 1 | Access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte lane enables |
| cpu_inhibit | input | 1 | Per-access cache inhibit |
| cpu_locked | input | 1 | Read-modify-write cycle marker |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus write |
| bus_lock | output | 1 | Locked cycle marker |
| bus_addr | output | 32 | Bus byte address |
| bus_be | output | 4 | Bus byte lanes |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Transfer done, one cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The bench runs a miss and four hits on every line, so a fill that runs out of order, drops a beat or validates the line too early shows up as a wrong word or an extra beat. It changes the bench memory behind a cached address and then reads it both inhibited and cached. A design that serves inhibited hits from the array would return the stale value, and one that allocates on bypass would turn the next cacheable read into a hit. Locked and partial-lane writes to cached lines check that the bypassed write still merges into the stored word. Freeze, disable and clear-all are each followed by reads whose beat counts would expose a fill or a hit that should not happen.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LINES  = 16;
    localparam int WPL    = 4;
    localparam int BE_W   = DATA_W / 8;
    localparam int BOFF_W = $clog2(BE_W);
    localparam int WOFF_W = $clog2(WPL);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;
    localparam int DEPTH  = LINES * WPL;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WOFF_W-1:0] woff_t;

    typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_SINGLE, ST_RESP} st_e;

    typedef struct packed {
        logic frz;
        logic en;
    } ctl_t;

    function automatic tag_t tag_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic idx_t idx_of(input logic [ADDR_W-1:0] a);
        return a[BOFF_W+WOFF_W +: IDX_W];
    endfunction

    function automatic woff_t woff_of(input logic [ADDR_W-1:0] a);
        return a[BOFF_W +: WOFF_W];
    endfunction
endpackage

// File: rtl/dcb_tags.sv
module dcb_tags
    import dcb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  idx_t             lk_idx,
    input  tag_t             lk_tag,
    output logic             lk_hit,
    input  logic             set_en,
    input  logic             inv_en,
    input  logic             clr_all,
    output logic [LINES-1:0] vld_o
);
    tag_t             tag_q [LINES];
    logic [LINES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            vld_q <= '0;
        end else begin
            if (inv_en) vld_q[lk_idx] <= 1'b0;
            if (set_en) vld_q[lk_idx] <= 1'b1;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_tag
        always_ff @(posedge clk) begin
            if (set_en && lk_idx == idx_t'(g)) tag_q[g] <= lk_tag;
        end
    end

    assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign vld_o  = vld_q;
endmodule

// File: rtl/dcb_data.sv
module dcb_data
    import dcb_pkg::*;
(
    input  logic              clk,
    input  idx_t              idx,
    input  woff_t             rd_woff,
    output logic [DATA_W-1:0] rd_word,
    input  logic              wr_en,
    input  woff_t             wr_woff,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int PTR_W = IDX_W + WOFF_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;

    assign wr_ptr  = {idx, wr_woff};
    assign rd_word = word_q[{idx, rd_woff}];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) word_q[wr_ptr][8*b +: 8] <= wr_data[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/dcb_ctrl.sv
module dcb_ctrl
    import dcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic              cpu_inhibit,
    input  logic              cpu_locked,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              hit,
    input  logic [DATA_W-1:0] cached_word,
    output logic              tag_set,
    output logic              tag_inv,
    output logic              dwr_en,
    output woff_t             dwr_woff,
    output logic [BE_W-1:0]   dwr_be,
    output logic [DATA_W-1:0] dwr_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_lock,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    st_e               st_q, st_d;
    woff_t             beat_q;
    logic [DATA_W-1:0] rdata_q;
    logic              bypass, ld_rd, ld_from_bus, beat_adv;

    assign bypass    = cpu_inhibit | cpu_locked | ~ctl.en;
    assign bus_wdata = cpu_wdata;
    assign cpu_rdata = rdata_q;

    always_comb begin
        st_d        = st_q;
        ld_rd       = 1'b0;
        ld_from_bus = 1'b0;
        beat_adv    = 1'b0;
        tag_set     = 1'b0;
        tag_inv     = 1'b0;
        dwr_en      = 1'b0;
        dwr_woff    = woff_of(cpu_addr);
        dwr_be      = cpu_be;
        dwr_data    = cpu_wdata;
        bus_req     = 1'b0;
        bus_we      = 1'b0;
        bus_lock    = 1'b0;
        bus_addr    = cpu_addr;
        bus_be      = cpu_be;
        cpu_ready   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        st_d   = ST_SINGLE;
                        dwr_en = hit;
                    end else if (!bypass && hit) begin
                        st_d  = ST_RESP;
                        ld_rd = 1'b1;
                    end else if (!bypass && !ctl.frz) begin
                        st_d    = ST_FILL;
                        tag_inv = 1'b1;
                    end else begin
                        st_d = ST_SINGLE;
                    end
                end
            end
            ST_SINGLE: begin
                bus_req  = 1'b1;
                bus_we   = cpu_we;
                bus_lock = cpu_locked;
                if (bus_ack) begin
                    st_d        = ST_RESP;
                    ld_rd       = ~cpu_we;
                    ld_from_bus = 1'b1;
                end
            end
            ST_FILL: begin
                bus_req  = 1'b1;
                bus_addr = {tag_of(cpu_addr), idx_of(cpu_addr), beat_q, {BOFF_W{1'b0}}};
                bus_be   = '1;
                if (bus_ack) begin
                    dwr_en      = 1'b1;
                    dwr_woff    = beat_q;
                    dwr_be      = '1;
                    dwr_data    = bus_rdata;
                    ld_rd       = (beat_q == woff_of(cpu_addr));
                    ld_from_bus = 1'b1;
                    beat_adv    = 1'b1;
                    if (beat_q == woff_t'(WPL-1)) begin
                        st_d    = ST_RESP;
                        tag_set = ~ctl.frz;
                    end
                end
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
                st_d      = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            beat_q  <= '0;
            rdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE) beat_q <= '0;
            else if (beat_adv)   beat_q <= beat_q + woff_t'(1);
            if (ld_rd) rdata_q <= ld_from_bus ? bus_rdata : cached_word;
        end
    end
endmodule

// File: rtl/dcache_bypass.sv
module dcache_bypass
    import dcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_wdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic              cpu_inhibit,
    input  logic              cpu_locked,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_lock,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);
    ctl_t              ctl_q;
    logic              clr_all, hit, tag_set, tag_inv, dwr_en;
    logic [LINES-1:0]  line_vld;
    logic [DATA_W-1:0] cached_word, dwr_data;
    logic [BE_W-1:0]   dwr_be;
    woff_t             dwr_woff;

    assign clr_all = cfg_we & cfg_wdata[2];

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (cfg_we) ctl_q <= '{frz: cfg_wdata[1], en: cfg_wdata[0]};
    end

    dcb_tags u_tags (
        .clk(clk), .rst(rst),
        .lk_idx(idx_of(cpu_addr)), .lk_tag(tag_of(cpu_addr)), .lk_hit(hit),
        .set_en(tag_set), .inv_en(tag_inv), .clr_all(clr_all), .vld_o(line_vld)
    );

    dcb_data u_data (
        .clk(clk), .idx(idx_of(cpu_addr)), .rd_woff(woff_of(cpu_addr)),
        .rd_word(cached_word), .wr_en(dwr_en), .wr_woff(dwr_woff),
        .wr_be(dwr_be), .wr_data(dwr_data)
    );

    dcb_ctrl u_ctrl (
        .clk(clk), .rst(rst), .ctl(ctl_q),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_inhibit(cpu_inhibit),
        .cpu_locked(cpu_locked), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .hit(hit), .cached_word(cached_word),
        .tag_set(tag_set), .tag_inv(tag_inv),
        .dwr_en(dwr_en), .dwr_woff(dwr_woff), .dwr_be(dwr_be), .dwr_data(dwr_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_lock(bus_lock),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker
    import dcb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [2:0]        cfg_wdata,
    input logic              frz,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [BE_W-1:0]   cpu_be,
    input logic              cpu_inhibit,
    input logic              cpu_locked,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_lock,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic              bus_ack,
    input logic [LINES-1:0]  line_vld
);
    assert_fill_fullword_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr != cpu_addr) |-> (bus_be == '1 && !bus_lock));

    assert_inhibit_single_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && cpu_inhibit) |-> (bus_addr == cpu_addr && bus_be == cpu_be));

    assert_lock_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_req && cpu_locked) |-> (bus_lock && bus_addr == cpu_addr && bus_we == cpu_we));

    assert_frozen_noalloc_R7: assert property (@(posedge clk) disable iff (rst)
        frz |=> ((line_vld & ~$past(line_vld)) == '0));

    assert_clear_all_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[2]) |=> (line_vld == '0));

    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_be)));

    assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);
endmodule

bind dcache_bypass dcb_checker u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .frz(ctl_q.frz),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_inhibit(cpu_inhibit), .cpu_locked(cpu_locked), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_lock(bus_lock), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_ack(bus_ack), .line_vld(line_vld)
);

// File: tb/dcache_bypass_test.sv
module dcache_bypass_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wdata = '0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_inhibit = 1'b0, cpu_locked = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        bus_req, bus_we, bus_lock;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] mem [256];
    int          nbeats = 0;
    logic [31:0] log_addr [8];
    logic [3:0]  log_be [8];
    logic        log_we [8];
    logic        log_lock [8];
    int          wcnt = 0;
    int          lat_sel = 0;
    logic [31:0] seen_addr = '0;

    always #5 clk = ~clk;

    dcache_bypass uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_inhibit(cpu_inhibit),
        .cpu_locked(cpu_locked), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_lock(bus_lock),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // Bus responder: variable latency 0..2 wait cycles, one-cycle ack.
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {8'(i), 8'(~i), 8'(i * 3), 8'hA5};
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
                wcnt = 0;
            end else if (bus_req && !rst) begin
                if (wcnt == 0) seen_addr = bus_addr;
                else chk(bus_addr == seen_addr, "R10 bus hold", bus_addr, seen_addr);
                if (wcnt >= lat_sel) begin
                    bus_ack = 1'b1;
                    if (nbeats < 8) begin
                        log_addr[nbeats] = bus_addr;
                        log_be[nbeats]   = bus_be;
                        log_we[nbeats]   = bus_we;
                        log_lock[nbeats] = bus_lock;
                    end
                    nbeats++;
                    if (bus_we) mem[bus_addr[9:2]] = merge(mem[bus_addr[9:2]], bus_wdata, bus_be);
                    else bus_rdata = mem[bus_addr[9:2]];
                    lat_sel = (lat_sel + 1) % 3;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] wd,
                       input logic [3:0] be, input logic inh, input logic lk,
                       output logic [31:0] rd, output int lat);
        @(negedge clk);
        nbeats = 0;
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        cpu_inhibit = inh; cpu_locked = lk; cpu_req = 1'b1;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (cpu_ready) break;
            if (lat > 200) begin
                chk(1'b0, "ready timeout", 32'(lat), 32'd200);
                break;
            end
        end
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic cfg(input logic [2:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, rd, exp, old;
        int lat;
        repeat (3) @(negedge clk);
        chk(cpu_ready == 1'b0, "R1 ready low in reset", 32'(cpu_ready), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_req == 1'b0, "R1 bus idle", 32'(bus_req), 32'd0);
        chk(cpu_ready == 1'b0, "R1 ready idle", 32'(cpu_ready), 32'd0);

        // R1/R8: enable resets to 0, so read is single transfer
        acc(0, 32'h10, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 1, "R1 disabled after reset", 32'(nbeats), 32'd1);
        chk(rd == mem[4], "R1 data", rd, mem[4]);
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R11 single pulse", 32'(cpu_ready), 32'd0);

        cfg(3'b001);

        // R2/R3 sweep over every line
        for (int i = 0; i < 16; i++) begin
            a = 32'(i * 16 + (i % 4) * 4);
            exp = mem[a[9:2]];
            acc(0, a, 0, 4'hF, 0, 0, rd, lat);
            chk(nbeats == 4, "R2 fill beats", 32'(nbeats), 32'd4);
            for (int k = 0; k < 4; k++) begin
                chk(log_addr[k] == 32'(i * 16 + k * 4) && log_be[k] == 4'hF && !log_we[k] && !log_lock[k],
                    "R2 fill order", log_addr[k], 32'(i * 16 + k * 4));
            end
            chk(rd == exp, "R2 fill word", rd, exp);
            for (int w = 0; w < 4; w++) begin
                a = 32'(i * 16 + w * 4);
                acc(0, a, 0, 4'hF, 0, 0, rd, lat);
                chk(nbeats == 0 && lat == 1, "R3 hit no bus", 32'(nbeats * 16 + lat), 32'd1);
                chk(rd == mem[a[9:2]], "R3 hit data", rd, mem[a[9:2]]);
            end
        end

        // R2 conflict eviction
        acc(0, 32'h120, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 4 && rd == mem[8'h48], "R2 conflict fill", rd, mem[8'h48]);
        acc(0, 32'h20, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 4, "R2 evicted refill", 32'(nbeats), 32'd4);

        // R4 inhibited read on a hit returns live device value
        old = mem[8];
        mem[8] = 32'hFEED_0001;
        acc(0, 32'h20, 0, 4'hF, 1, 0, rd, lat);
        chk(nbeats == 1 && log_addr[0] == 32'h20, "R4 single beat", 32'(nbeats), 32'd1);
        chk(rd == 32'hFEED_0001, "R4 live data", rd, 32'hFEED_0001);
        acc(0, 32'h20, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 0 && rd == old, "R4 cache unchanged", rd, old);
        acc(0, 32'h2C4, 0, 4'b0100, 1, 0, rd, lat);
        chk(nbeats == 1 && log_be[0] == 4'b0100, "R4 requested lanes", 32'(log_be[0]), 32'h4);
        acc(0, 32'h2C4, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 4, "R4 no allocation", 32'(nbeats), 32'd4);

        // R5 locked cycles
        acc(0, 32'h30, 0, 4'hF, 0, 1, rd, lat);
        chk(nbeats == 1 && log_lock[0] && !log_we[0], "R5 locked read", 32'(nbeats), 32'd1);
        chk(rd == mem[12], "R5 locked data", rd, mem[12]);
        acc(1, 32'h30, 32'h0BAD_F00D, 4'hF, 0, 1, rd, lat);
        chk(nbeats == 1 && log_lock[0] && log_we[0], "R5 locked write", 32'(nbeats), 32'd1);
        chk(mem[12] == 32'h0BAD_F00D, "R5 write reached bus", mem[12], 32'h0BAD_F00D);
        acc(0, 32'h30, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 0 && rd == 32'h0BAD_F00D, "R6 bypassed write updates hit", rd, 32'h0BAD_F00D);

        // R6 partial write hit and write miss
        exp = merge(mem[17], 32'hDEAD_BEEF, 4'b0011);
        acc(1, 32'h44, 32'hDEAD_BEEF, 4'b0011, 0, 0, rd, lat);
        chk(nbeats == 1 && log_be[0] == 4'b0011 && log_we[0] && !log_lock[0], "R6 write beat", 32'(log_be[0]), 32'h3);
        acc(0, 32'h44, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 0 && rd == exp, "R6 merged hit", rd, exp);
        acc(1, 32'h344, 32'h1234_5678, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 1, "R6 write miss single", 32'(nbeats), 32'd1);
        acc(0, 32'h44, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 0 && rd == exp, "R6 no write allocate", rd, exp);
        acc(0, 32'h344, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 4 && rd == 32'h1234_5678, "R6 miss then fill", rd, 32'h1234_5678);

        // R7 freeze
        cfg(3'b011);
        acc(0, 32'h50, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 0 && rd == mem[20], "R7 frozen hit", rd, mem[20]);
        acc(0, 32'h150, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 1 && rd == mem[84], "R7 frozen miss single", 32'(nbeats), 32'd1);
        acc(0, 32'h150, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 1, "R7 frozen no alloc", 32'(nbeats), 32'd1);
        acc(0, 32'h50, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 0, "R7 line kept", 32'(nbeats), 32'd0);

        // R8 disabled
        cfg(3'b000);
        mem[24] = 32'hC0FF_EE00;
        acc(0, 32'h60, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 1 && rd == 32'hC0FF_EE00, "R8 disabled bypass", rd, 32'hC0FF_EE00);

        // R9 clear-all
        cfg(3'b101);
        acc(0, 32'h70, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 4, "R9 cleared line refills", 32'(nbeats), 32'd4);
        acc(0, 32'h80, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 4 && rd == mem[32], "R9 enable kept", rd, mem[32]);
        acc(0, 32'h80, 0, 4'hF, 0, 0, rd, lat);
        chk(nbeats == 0, "R9 clear not sticky", 32'(nbeats), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule